// File: doc/BRIEF.md
# Paged Burst Write Cache

This block is a write-side buffer placed in front of a memory array that is programmed a page at a time and needs a long, fixed recovery time after each page. A write command opens with a start strobe that carries a 13-bit array address. Data bytes then stream into a 64-byte cache, arranged as eight cache pages of eight bytes each. Nothing reaches the array until a stop strobe closes the command.

On stop, the cache is drained one cache page at a time. Each drained page goes out through a page-wide write port, which carries a per-byte enable mask, and is followed by a fixed programming wait. Cache pages that received no bytes are passed over without any write or wait. While the drain runs, the block reports busy and every incoming strobe is dropped.

The byte placement is the part that needs care. The first byte always lands in cache page 0, at the byte offset taken from the low address bits. Loading then runs through the following cache pages, and at the end of the cache it wraps round to the start of page 0. On the array side, cache page 0 always goes to the array page that holds the start address, and each later cache page goes to the next array page.

Top module: `page_burst_cache`

## Requirements
- R1: After reset, `busy_o` and `wr_en_o` are low, and `wr_mask_o` is all zero.
- R2: After a start strobe, the first byte is stored in cache page 0 at byte offset `start_addr_i[2:0]`. Each further byte goes to the next cache byte position, through cache pages 1 to 7.
- R3: The load position wraps from the last byte of cache page 7 to byte 0 of cache page 0. Bytes past 64 overwrite positions that were already loaded, and the last byte written to a position is the one that is committed.
- R4: No array write and no busy happen before the stop strobe, however many bytes have been loaded. `busy_o` rises in the cycle after an accepted stop.
- R5: Cache page k is written to array page (`start_addr_i[12:3]` + k) modulo 1024. Array pages wrap at the top of the address space.
- R6: Every page write is a single-cycle `wr_en_o` pulse, followed by `WAIT_CYCLES` idle wait cycles whether the page is full or partial. Each cache page that is passed over costs one cycle. Busy lasts 8 + n x `WAIT_CYCLES` cycles, where n is the number of written pages.
- R7: Bit j of `wr_mask_o` is set only when byte position j of that cache page was loaded. Loaded byte j appears on `wr_data_o[8j+7:8j]`.
- R8: While `busy_o` is high, start, byte and stop strobes have no effect. An ignored start does not arm the block for a later stop.
- R9: Cache pages that hold no loaded byte produce no write pulse.
- R10: A stop with no loaded byte, or with no preceding start, leaves `busy_o` low and causes no write.
- R11: A start clears every loaded byte. When strobes coincide, start takes priority over stop, and stop takes priority over byte. A byte that arrives together with a start or a stop is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a write command |
| start_addr_i | input | 13 | Array start address, sampled with `start_i` |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Ends the command and starts the drain |
| busy_o | output | 1 | Drain in progress; strobes are ignored |
| wr_en_o | output | 1 | One-cycle array page write pulse |
| wr_page_o | output | 10 | Target array page number |
| wr_data_o | output | 64 | Page data, with byte j in bits [8j+7:8j] |
| wr_mask_o | output | 8 | Per-byte write enables |

## Verification
The bench targets the following cases:
- Bursts that start at a nonzero offset and fill the whole cache. A design that failed to wrap into the head of page 0 would leave those mask bits clear or write the wrong data.
- Bursts of more than 64 bytes. A design that kept the older bytes would fail the data check.
- A burst that begins at the last array page. It would expose a target page that does not roll over to page 0.
- Sparse bursts that touch one or two cache pages. These catch a drain that writes empty pages or waits for the wrong length, because every write's cycle offset within busy is checked against the expected timeline.
- Strobes sent during busy, and coinciding strobes. These would reveal a design that latched a start while busy or took a byte together with a start.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COMMIT = 2'd1,
    ST_WAIT   = 2'd2
  } pbc_state_e;

  // next position in a ring of 'size' entries
  function automatic int unsigned ring_next(int unsigned idx, int unsigned size);
    return (idx + 1 >= size) ? 0 : idx + 1;
  endfunction

  // array page receiving cache page 'cp' of a burst based at 'base'
  function automatic int unsigned page_target(int unsigned base, int unsigned cp,
                                              int unsigned span);
    return (base + cp) % span;
  endfunction

endpackage

// File: rtl/pbc_cache_store.sv
module pbc_cache_store #(
  parameter int PAGE_BYTES = 8,
  parameter int NUM_PAGES  = 8,
  parameter int DATA_W     = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr_i,
  input  logic                           we_i,
  input  logic [$clog2(PAGE_BYTES*NUM_PAGES)-1:0] widx_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [$clog2(NUM_PAGES)-1:0]   rd_page_i,
  output logic [PAGE_BYTES*DATA_W-1:0]   rd_data_o,
  output logic [PAGE_BYTES-1:0]          rd_mask_o,
  output logic                           any_vld_o
);
  localparam int CACHE_BYTES = PAGE_BYTES * NUM_PAGES;
  localparam int IDX_W       = $clog2(CACHE_BYTES);
  localparam int OFS_W       = $clog2(PAGE_BYTES);

  logic [DATA_W-1:0]      mem_w [CACHE_BYTES];
  logic [CACHE_BYTES-1:0] vld_w;

  for (genvar b = 0; b < CACHE_BYTES; b++) begin : g_byte
    logic              vld_q;
    logic [DATA_W-1:0] data_q;
    logic              hit;
    assign hit = we_i && (widx_i == IDX_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q <= 1'b0;
      else if (clr_i)  vld_q <= 1'b0;
      else if (hit)    vld_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) data_q <= wdata_i;
    end

    assign vld_w[b] = vld_q;
    assign mem_w[b] = data_q;
  end

  always_comb begin
    for (int j = 0; j < PAGE_BYTES; j++) begin
      rd_data_o[j*DATA_W +: DATA_W] = mem_w[{rd_page_i, OFS_W'(j)}];
      rd_mask_o[j]                  = vld_w[{rd_page_i, OFS_W'(j)}];
    end
  end

  assign any_vld_o = |vld_w;

endmodule

// File: rtl/pbc_commit_fsm.sv
module pbc_commit_fsm #(
  parameter int NUM_PAGES   = 8,
  parameter int WAIT_CYCLES = 50000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         go_i,
  input  logic                         page_has_data_i,
  output logic                         busy_o,
  output logic                         commit_o,
  output logic [$clog2(NUM_PAGES)-1:0] cpage_o
);
  import pbc_pkg::*;

  localparam int PG_W  = $clog2(NUM_PAGES);
  localparam int CNT_W = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);

  pbc_state_e       state_q;
  logic [PG_W-1:0]  cp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_page;

  assign last_page = (cp_q == PG_W'(NUM_PAGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cp_q    <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go_i) begin
            state_q <= ST_COMMIT;
            cp_q    <= '0;
          end
        end
        ST_COMMIT: begin
          if (page_has_data_i) begin
            state_q <= ST_WAIT;
            cnt_q   <= CNT_W'(WAIT_CYCLES - 1);
          end else if (last_page) begin
            state_q <= ST_IDLE;
          end else begin
            cp_q <= PG_W'(ring_next(32'(cp_q), NUM_PAGES));
          end
        end
        ST_WAIT: begin
          if (cnt_q == '0) begin
            if (last_page) state_q <= ST_IDLE;
            else begin
              state_q <= ST_COMMIT;
              cp_q    <= PG_W'(ring_next(32'(cp_q), NUM_PAGES));
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign commit_o = (state_q == ST_COMMIT) && page_has_data_i;
  assign cpage_o  = cp_q;

endmodule

// File: rtl/page_burst_cache.sv
module page_burst_cache #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 8,
  parameter int NUM_PAGES   = 8,
  parameter int WAIT_CYCLES = 50000
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start_i,
  input  logic [ADDR_W-1:0]                   start_addr_i,
  input  logic                                byte_vld_i,
  input  logic [DATA_W-1:0]                   byte_i,
  input  logic                                stop_i,
  output logic                                busy_o,
  output logic                                wr_en_o,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] wr_page_o,
  output logic [PAGE_BYTES*DATA_W-1:0]        wr_data_o,
  output logic [PAGE_BYTES-1:0]               wr_mask_o
);
  import pbc_pkg::*;

  localparam int OFS_W       = $clog2(PAGE_BYTES);
  localparam int PG_W        = $clog2(NUM_PAGES);
  localparam int CACHE_BYTES = PAGE_BYTES * NUM_PAGES;
  localparam int IDX_W       = $clog2(CACHE_BYTES);
  localparam int PAGE_NUM_W  = ADDR_W - OFS_W;
  localparam int PAGE_SPAN   = 1 << PAGE_NUM_W;

  logic                  armed_q;
  logic [IDX_W-1:0]      ptr_q;
  logic [PAGE_NUM_W-1:0] base_q;

  // named events, also used by the checker
  logic start_acc, stop_acc, byte_acc, drain_go, page_commit;
  logic cache_any_vld;
  logic [PG_W-1:0]               cpage;
  logic [PAGE_BYTES*DATA_W-1:0]  page_data;
  logic [PAGE_BYTES-1:0]         page_mask;

  assign start_acc = !busy_o && start_i;
  assign stop_acc  = !busy_o && !start_i && stop_i && armed_q;
  assign byte_acc  = !busy_o && !start_i && !stop_i && armed_q && byte_vld_i;
  assign drain_go  = stop_acc && cache_any_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ptr_q   <= '0;
      base_q  <= '0;
    end else if (start_acc) begin
      armed_q <= 1'b1;
      ptr_q   <= IDX_W'(start_addr_i[OFS_W-1:0]);
      base_q  <= start_addr_i[ADDR_W-1:OFS_W];
    end else if (stop_acc) begin
      armed_q <= 1'b0;
    end else if (byte_acc) begin
      ptr_q <= IDX_W'(ring_next(32'(ptr_q), CACHE_BYTES));
    end
  end

  pbc_cache_store #(
    .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .clr_i(start_acc), .we_i(byte_acc), .widx_i(ptr_q), .wdata_i(byte_i),
    .rd_page_i(cpage), .rd_data_o(page_data), .rd_mask_o(page_mask),
    .any_vld_o(cache_any_vld)
  );

  pbc_commit_fsm #(
    .NUM_PAGES(NUM_PAGES), .WAIT_CYCLES(WAIT_CYCLES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .go_i(drain_go), .page_has_data_i(|page_mask),
    .busy_o(busy_o), .commit_o(page_commit), .cpage_o(cpage)
  );

  assign wr_en_o   = page_commit;
  assign wr_page_o = PAGE_NUM_W'(page_target(32'(base_q), 32'(cpage), PAGE_SPAN));
  assign wr_data_o = page_commit ? page_data : '0;
  assign wr_mask_o = page_commit ? page_mask : '0;

endmodule

// File: rtl/pbc_checker.sv
module pbc_checker #(
  parameter int PAGE_W      = 10,
  parameter int PAGE_BYTES  = 8,
  parameter int NUM_PAGES   = 8,
  parameter int WAIT_CYCLES = 50000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_i,
  input logic              busy_o,
  input logic              wr_en_o,
  input logic [PAGE_W-1:0] wr_page_o,
  input logic [PAGE_BYTES-1:0] wr_mask_o,
  input logic              stop_acc,
  input logic              cache_any_vld
);
  logic [15:0]       gap_q;
  logic              seen_q;
  logic [PAGE_W-1:0] last_pg_q;
  logic [PAGE_W-1:0] pg_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '0;
      seen_q    <= 1'b0;
      last_pg_q <= '0;
    end else begin
      if (wr_en_o) begin
        gap_q     <= 16'd1;
        seen_q    <= 1'b1;
        last_pg_q <= wr_page_o;
      end else begin
        if (gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
        if (!busy_o) seen_q <= 1'b0;
      end
    end
  end

  assign pg_step = wr_page_o - last_pg_q;

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  p_wait_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && seen_q) |-> (32'(gap_q) > WAIT_CYCLES));

  p_mask_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_mask_o != '0));

  p_busy_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));

  p_write_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> busy_o);

  p_page_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && seen_q) |-> (pg_step != '0 && 32'(pg_step) < NUM_PAGES));

  p_empty_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_acc && !cache_any_vld) |=> !busy_o);

endmodule

bind page_burst_cache pbc_checker #(
  .PAGE_W(PAGE_NUM_W), .PAGE_BYTES(PAGE_BYTES),
  .NUM_PAGES(NUM_PAGES), .WAIT_CYCLES(WAIT_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .busy_o(busy_o),
  .wr_en_o(wr_en_o), .wr_page_o(wr_page_o), .wr_mask_o(wr_mask_o),
  .stop_acc(stop_acc), .cache_any_vld(cache_any_vld)
);

// File: tb/page_burst_cache_tb_top.sv
`timescale 1ns/100ps
module page_burst_cache_tb_top;
  localparam int W  = 5;
  localparam int NV = 7;
  // fields: start address [28:16], byte count [15:8], first data value [7:0]
  localparam logic [28:0] VEC [NV] = '{
    {13'h0000, 8'd8,  8'h10},   // one full aligned page
    {13'h001A, 8'd64, 8'h40},   // offset 2, full cache, head wrap (R3)
    {13'h1FFD, 8'd5,  8'hC0},   // last array page, page wrap (R5)
    {13'h0105, 8'd70, 8'h01},   // overflow overwrite (R3)
    {13'h0010, 8'd20, 8'h80},   // partial last page (R7)
    {13'h0047, 8'd2,  8'hE0},   // one byte in each of two pages
    {13'h0000, 8'd0,  8'h00}    // start then stop, nothing loaded (R10)
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, byte_vld_i = 0, stop_i = 0;
  logic [12:0] start_addr_i = '0;
  logic [7:0]  byte_i = '0;
  logic busy_o, wr_en_o;
  logic [9:0]  wr_page_o;
  logic [63:0] wr_data_o;
  logic [7:0]  wr_mask_o;

  always #2.5 clk = ~clk;

  page_burst_cache #(.WAIT_CYCLES(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i),
    .busy_o(busy_o), .wr_en_o(wr_en_o), .wr_page_o(wr_page_o),
    .wr_data_o(wr_data_o), .wr_mask_o(wr_mask_o));

  int checks = 0, failures = 0;

  // monitor: sole writer of the capture log
  int          cap_cnt = 0, busy_cnt = 0;
  logic [9:0]  cap_page [256];
  logic [63:0] cap_data [256];
  logic [7:0]  cap_mask [256];
  int          cap_t    [256];
  always @(negedge clk) begin
    if (wr_en_o && cap_cnt < 256) begin
      cap_page[cap_cnt] = wr_page_o;
      cap_data[cap_cnt] = wr_data_o;
      cap_mask[cap_cnt] = wr_mask_o;
      cap_t[cap_cnt]    = busy_cnt;
      cap_cnt++;
    end
    if (busy_o) busy_cnt++;
  end

  // reference model of the cache
  logic [7:0] m_data [64];
  logic [63:0] m_vld;
  int m_ptr, m_base;

  task automatic m_start(input logic [12:0] a);
    m_vld = '0; m_ptr = int'(a[2:0]); m_base = int'(a[12:3]);
  endtask
  task automatic m_byte(input logic [7:0] d);
    m_data[m_ptr] = d; m_vld[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 64;
  endtask

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stimulus, each task entered and left at a falling edge
  task automatic do_start(input logic [12:0] a);
    start_i = 1; start_addr_i = a; @(negedge clk); start_i = 0;
  endtask
  task automatic do_byte(input logic [7:0] d);
    byte_vld_i = 1; byte_i = d; @(negedge clk); byte_vld_i = 0;
  endtask
  task automatic do_stop();
    stop_i = 1; @(negedge clk); stop_i = 0;
  endtask
  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  // compare a drain against the model; base indexes captured before stop
  task automatic compare_drain(input string tag, input int cbase, input int bbase);
    int t = 0, k = 0;
    for (int cp = 0; cp < 8; cp++) begin
      logic [7:0] m = m_vld[cp*8 +: 8];
      if (m != 0) begin
        int i = cbase + k;
        check({"R5 page ", tag}, cap_page[i] == 10'((m_base + cp) % 1024), cap_page[i], (m_base + cp) % 1024);
        check({"R7 mask ", tag}, cap_mask[i] == m, cap_mask[i], m);
        check({"R6 timing ", tag}, (cap_t[i] - bbase) == t, cap_t[i] - bbase, t);
        for (int j = 0; j < 8; j++)
          if (m[j])
            check({"R2 data ", tag}, cap_data[i][j*8 +: 8] == m_data[cp*8 + j],
                  cap_data[i][j*8 +: 8], m_data[cp*8 + j]);
        k++; t += 1 + W;
      end else t += 1;
    end
    check({"R9 write count ", tag}, (cap_cnt - cbase) == k, cap_cnt - cbase, k);
    check({"R6 busy length ", tag}, (busy_cnt - bbase) == ((k == 0) ? 0 : t),
          busy_cnt - bbase, (k == 0) ? 0 : t);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cb, bb;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", busy_o == 0, busy_o, 0);
    check("R1 wr_en", wr_en_o == 0, wr_en_o, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 mask", wr_mask_o == 0, wr_mask_o, 0);

    for (int v = 0; v < NV; v++) begin
      logic [12:0] a = VEC[v][28:16];
      int n = int'(VEC[v][15:8]);
      logic [7:0] s = VEC[v][7:0];
      do_start(a); m_start(a);
      for (int i = 0; i < n; i++) begin
        do_byte(8'(s + 8'(i))); m_byte(8'(s + 8'(i)));
      end
      cb = cap_cnt; bb = busy_cnt;
      // R4: nothing written and not busy before stop, even past 64 bytes
      check("R4 no early write", (cap_cnt == cb) && !busy_o, busy_o, 0);
      do_stop();
      if (n > 0) check("R4 busy after stop", busy_o == 1, busy_o, 1);
      else       check("R10 empty stop", busy_o == 0, busy_o, 0);
      wait_idle();
      compare_drain($sformatf("vec%0d", v), cb, bb);
    end

    // R8: strobes during busy are ignored and do not arm
    do_start(13'h0000); m_start(13'h0000);
    for (int i = 0; i < 4; i++) begin do_byte(8'(8'h30 + 8'(i))); m_byte(8'(8'h30 + 8'(i))); end
    cb = cap_cnt; bb = busy_cnt;
    do_stop();
    do_start(13'h0800); do_byte(8'hAB); do_byte(8'hCD); do_stop();
    wait_idle();
    compare_drain("R8 busy strobes", cb, bb);
    cb = cap_cnt; bb = busy_cnt;
    do_stop(); wait_idle();
    check("R8 not armed", (cap_cnt == cb) && (busy_cnt == bb), busy_cnt - bb, 0);
    check("R10 stop without start", busy_cnt == bb, busy_cnt - bb, 0);

    // R11: a second start clears earlier bytes
    do_start(13'h0000);
    for (int i = 0; i < 8; i++) do_byte(8'hF0);
    do_start(13'h0040); m_start(13'h0040);
    do_byte(8'h90); m_byte(8'h90); do_byte(8'h91); m_byte(8'h91);
    cb = cap_cnt; bb = busy_cnt;
    do_stop(); wait_idle();
    compare_drain("R11 restart clears", cb, bb);
    check("R11 single page", (cap_cnt - cb) == 1, cap_cnt - cb, 1);

    // R11: byte coinciding with start is dropped
    start_i = 1; start_addr_i = 13'h0008; byte_vld_i = 1; byte_i = 8'hAA;
    @(negedge clk); start_i = 0; byte_vld_i = 0;
    m_start(13'h0008);
    do_byte(8'h55); m_byte(8'h55);
    cb = cap_cnt; bb = busy_cnt;
    do_stop(); wait_idle();
    compare_drain("R11 start over byte", cb, bb);
    check("R11 offset0 data", cap_data[cb][7:0] == 8'h55, cap_data[cb][7:0], 8'h55);

    // R11: byte coinciding with stop is dropped
    do_start(13'h0000); m_start(13'h0000);
    do_byte(8'h11); m_byte(8'h11);
    cb = cap_cnt; bb = busy_cnt;
    stop_i = 1; byte_vld_i = 1; byte_i = 8'h22; @(negedge clk); stop_i = 0; byte_vld_i = 0;
    wait_idle();
    compare_drain("R11 stop over byte", cb, bb);
    check("R11 stop mask", cap_mask[cb] == 8'h01, cap_mask[cb], 8'h01);

    finish_run();
  end
endmodule